// File: doc/BRIEF.md
# E3 Loss-of-Signal and Alarm-Indication Monitor

This block watches a recovered E3 serial bit stream, taking one bit on each cycle where the bit enable is high. An upstream framer supplies a frame-boundary strobe. The block reports two defect levels and a one-cycle change event for each level. The events are meant to feed interrupt logic.

The loss-of-signal defect is based on runs of zeros. It is declared after a long unbroken zero run. It clears only after a full window of bits that contains no short zero run. The alarm-indication defect is based on how many zeros each frame holds. It is declared when consecutive frames are nearly all ones, and cleared when consecutive frames carry enough zeros.

A format select input sets the frame length. The frame position counter free-runs between strobes, so a missing strobe does not stall the alarm check.

Top module: `e3_defect_mon`

## Requirements
- R1: During and after reset, `los_o`, `ais_o`, `los_chg_o` and `ais_chg_o` are all 0.
- R2: `los_o` rises on the clock edge that takes the 32nd consecutive zero bit. A run of 31 zeros followed by a one does not set it.
- R3: While `los_o` is 1, it clears on the 32nd accepted bit of a window that holds no run of 4 consecutive zeros. The window starts with the bit after the declaring bit.
- R4: While `los_o` is 1, the 4th zero of any zero run, and every further zero of that run, restarts the clearing window. A run of 3 zeros does not restart it.
- R5: A frame is 4296 bits when `fmt_sel_i` is 0 and 1536 bits when it is 1. `frame_start_i` marks the first bit of a frame. A strobe that arrives before the frame's last bit throws away the partial frame. Without a strobe, a new frame starts right after the last bit.
- R6: When `ais_o` is 0, it rises on the last bit of the second consecutive frame that holds 7 or fewer zeros.
- R7: When `ais_o` is 1, it clears on the last bit of the second consecutive frame that holds more than 7 zeros.
- R8: A frame that does not meet the condition for changing the current `ais_o` level resets the two-frame count.
- R9: `los_chg_o` and `ais_chg_o` are high for exactly one cycle, in the cycle where the matching level has just changed.
- R10: Cycles with `bit_en_i` low change no state. On such cycles `bit_i` and `frame_start_i` are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_en_i | input | 1 | Qualifies `bit_i` and `frame_start_i` |
| bit_i | input | 1 | Recovered serial data bit |
| frame_start_i | input | 1 | First bit of a frame |
| fmt_sel_i | input | 1 | 0: 4296-bit frame, 1: 1536-bit frame |
| los_o | output | 1 | Loss-of-signal level |
| ais_o | output | 1 | Alarm-indication level |
| los_chg_o | output | 1 | One-cycle pulse when `los_o` changes |
| ais_chg_o | output | 1 | One-cycle pulse when `ais_o` changes |

## Verification
All four outputs come from registers that update on the edge that takes the deciding bit. A result is therefore due in the very cycle after that bit's edge. For the alarm level, the deciding bit is the frame's last bit. The bench drives each bit on the falling edge and reads outputs shortly after the following rising edge. It checks levels and change pulses exactly at the deciding bit, and one bit before it where a boundary matters. Each change pulse is checked again one bit later to confirm it has dropped.

// File: rtl/e3_defect_pkg.sv
package e3_defect_pkg;
  typedef enum logic {
    FMT_LONG  = 1'b0,
    FMT_SHORT = 1'b1
  } e3_fmt_e;

  typedef struct packed {
    logic done;    // last bit of a frame taken this cycle
    logic sparse;  // frame zero count below threshold
  } frame_sum_t;
endpackage

// File: rtl/e3_los_det.sv
module e3_los_det #(
  parameter int unsigned LOS_RUN = 32,
  parameter int unsigned CLR_WIN = 32,
  parameter int unsigned CLR_RUN = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_en_i,
  input  logic bit_i,
  output logic los_o,
  output logic chg_o
);
  localparam int unsigned RW = $clog2(LOS_RUN + 1);
  localparam int unsigned WW = $clog2(CLR_WIN + 1);

  logic [RW-1:0] run_q, run_nx;
  logic [WW-1:0] win_q;
  logic          los_q, chg_q;

  always_comb begin
    if (bit_i)                       run_nx = '0;
    else if (run_q == RW'(LOS_RUN))  run_nx = run_q;
    else                             run_nx = run_q + RW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= '0;
      win_q <= '0;
      los_q <= 1'b0;
      chg_q <= 1'b0;
    end else begin
      chg_q <= 1'b0;
      if (bit_en_i) begin
        run_q <= run_nx;
        if (!los_q) begin
          if (run_nx == RW'(LOS_RUN)) begin
            los_q <= 1'b1;
            chg_q <= 1'b1;
            win_q <= '0;
          end
        end else if (run_nx >= RW'(CLR_RUN)) begin
          win_q <= '0;  // window restarts after a long zero run
        end else if (win_q == WW'(CLR_WIN - 1)) begin
          los_q <= 1'b0;
          chg_q <= 1'b1;
          win_q <= '0;
        end else begin
          win_q <= win_q + WW'(1);
        end
      end
    end
  end

  assign los_o = los_q;
  assign chg_o = chg_q;
endmodule

// File: rtl/e3_frame_zcnt.sv
module e3_frame_zcnt
  import e3_defect_pkg::*;
#(
  parameter int unsigned LEN_LONG  = 4296,
  parameter int unsigned LEN_SHORT = 1536,
  parameter int unsigned ZSAT      = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       bit_en_i,
  input  logic       bit_i,
  input  logic       frame_start_i,
  input  logic       fmt_sel_i,
  output frame_sum_t sum_o
);
  localparam int unsigned LMAX = (LEN_LONG > LEN_SHORT) ? LEN_LONG : LEN_SHORT;
  localparam int unsigned PW   = $clog2(LMAX);
  localparam int unsigned ZW   = $clog2(ZSAT + 1);

  logic [PW-1:0] pos_q, pos_cur, len_m1;
  logic [ZW-1:0] zc_q, zc_cur, zc_nx;
  logic          last;

  always_comb begin
    len_m1  = (e3_fmt_e'(fmt_sel_i) == FMT_SHORT) ? PW'(LEN_SHORT - 1) : PW'(LEN_LONG - 1);
    pos_cur = frame_start_i ? '0 : pos_q;
    zc_cur  = frame_start_i ? '0 : zc_q;
    if (!bit_i && zc_cur != ZW'(ZSAT)) zc_nx = zc_cur + ZW'(1);
    else                               zc_nx = zc_cur;
    last         = pos_cur >= len_m1;
    sum_o.done   = bit_en_i && last;
    sum_o.sparse = zc_nx < ZW'(ZSAT);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q <= '0;
      zc_q  <= '0;
    end else if (bit_en_i) begin
      if (last) begin
        pos_q <= '0;
        zc_q  <= '0;
      end else begin
        pos_q <= pos_cur + PW'(1);
        zc_q  <= zc_nx;
      end
    end
  end
endmodule

// File: rtl/e3_ais_det.sv
module e3_ais_det
  import e3_defect_pkg::*;
#(
  parameter int unsigned PERSIST = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  frame_sum_t sum_i,
  output logic       ais_o,
  output logic       chg_o
);
  localparam int unsigned CW = $clog2(PERSIST + 1);

  logic [CW-1:0] pers_q;
  logic          ais_q, chg_q, toward;

  // frame argues for the opposite of the current level
  assign toward = ais_q ? !sum_i.sparse : sum_i.sparse;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pers_q <= '0;
      ais_q  <= 1'b0;
      chg_q  <= 1'b0;
    end else begin
      chg_q <= 1'b0;
      if (sum_i.done) begin
        if (!toward) begin
          pers_q <= '0;
        end else if (pers_q == CW'(PERSIST - 1)) begin
          pers_q <= '0;
          ais_q  <= !ais_q;
          chg_q  <= 1'b1;
        end else begin
          pers_q <= pers_q + CW'(1);
        end
      end
    end
  end

  assign ais_o = ais_q;
  assign chg_o = chg_q;
endmodule

// File: rtl/e3_defect_mon.sv
module e3_defect_mon
  import e3_defect_pkg::*;
#(
  parameter int unsigned LOS_RUN   = 32,
  parameter int unsigned CLR_WIN   = 32,
  parameter int unsigned CLR_RUN   = 4,
  parameter int unsigned LEN_LONG  = 4296,
  parameter int unsigned LEN_SHORT = 1536,
  parameter int unsigned ZSAT      = 8,
  parameter int unsigned PERSIST   = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_en_i,
  input  logic bit_i,
  input  logic frame_start_i,
  input  logic fmt_sel_i,
  output logic los_o,
  output logic ais_o,
  output logic los_chg_o,
  output logic ais_chg_o
);
  frame_sum_t frame_sum;

  e3_los_det #(
    .LOS_RUN(LOS_RUN), .CLR_WIN(CLR_WIN), .CLR_RUN(CLR_RUN)
  ) u_los (
    .clk_i(clk_i), .rst_ni(rst_ni), .bit_en_i(bit_en_i), .bit_i(bit_i),
    .los_o(los_o), .chg_o(los_chg_o)
  );

  e3_frame_zcnt #(
    .LEN_LONG(LEN_LONG), .LEN_SHORT(LEN_SHORT), .ZSAT(ZSAT)
  ) u_frm (
    .clk_i(clk_i), .rst_ni(rst_ni), .bit_en_i(bit_en_i), .bit_i(bit_i),
    .frame_start_i(frame_start_i), .fmt_sel_i(fmt_sel_i), .sum_o(frame_sum)
  );

  e3_ais_det #(.PERSIST(PERSIST)) u_ais (
    .clk_i(clk_i), .rst_ni(rst_ni), .sum_i(frame_sum),
    .ais_o(ais_o), .chg_o(ais_chg_o)
  );
endmodule

// File: rtl/e3_defect_mon_chk.sv
module e3_defect_mon_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic bit_en_i,
  input logic bit_i,
  input logic los_o,
  input logic ais_o,
  input logic los_chg_o,
  input logic ais_chg_o
);
  // R1
  always_comb if (!rst_ni) begin
    reset_quiet_chk: assert (!los_chg_o && !ais_chg_o);
  end

  // R9
  los_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    los_chg_o |-> (los_o != $past(los_o)));
  // R9
  ais_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ais_chg_o |-> (ais_o != $past(ais_o)));
  // R9
  los_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    los_chg_o |=> !los_chg_o);
  // R9
  ais_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ais_chg_o |=> !ais_chg_o);
  // R10
  los_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_en_i |=> $stable(los_o));
  // R10
  ais_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_en_i |=> $stable(ais_o));
  // R2
  los_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(los_o) |-> $past(bit_en_i && !bit_i));
  // R6
  ais_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ais_o) |-> $past(bit_en_i));
endmodule

bind e3_defect_mon e3_defect_mon_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .bit_en_i(bit_en_i), .bit_i(bit_i),
  .los_o(los_o), .ais_o(ais_o), .los_chg_o(los_chg_o), .ais_chg_o(ais_chg_o)
);

// File: tb/e3_defect_mon_bench.sv
module e3_defect_mon_bench;
  localparam int LLONG  = 4296;
  localparam int LSHORT = 1536;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_en = 1'b0, bit_d = 1'b1, fs = 1'b0, fmt = 1'b1;
  logic los, ais, los_chg, ais_chg;
  int vectors = 0, errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  e3_defect_mon u_e3_defect_mon (
    .clk_i(clk), .rst_ni(rst_n), .bit_en_i(bit_en), .bit_i(bit_d),
    .frame_start_i(fs), .fmt_sel_i(fmt), .los_o(los), .ais_o(ais),
    .los_chg_o(los_chg), .ais_chg_o(ais_chg)
  );

  task automatic check(input string req, input logic act, input logic exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic send(input logic b, input logic strobe);
    @(negedge clk);
    bit_en = 1'b1; bit_d = b; fs = strobe;
    @(posedge clk); #2;
  endtask

  task automatic send_n(input logic b, input int n);
    for (int i = 0; i < n; i++) send(b, 1'b0);
  endtask

  // frame with nz zeros at tail positions len-2, len-4, ...; stops before last bit
  task automatic frame_head(input int len, input int nz, input logic strobe);
    for (int i = 0; i < len - 1; i++)
      send(!((i >= len - 2*nz) && ((len - i) % 2 == 0)), strobe && (i == 0));
  endtask

  task automatic frame(input int len, input int nz, input logic strobe);
    frame_head(len, nz, strobe);
    send(1'b1, 1'b0);
  endtask

  task automatic t_reset;
    check("R1 los", los, 1'b0);
    check("R1 ais", ais, 1'b0);
    check("R1 los_chg", los_chg, 1'b0);
    check("R1 ais_chg", ais_chg, 1'b0);
  endtask

  task automatic t_los_declare;
    send_n(1'b0, 31);
    send(1'b1, 1'b0);
    check("R2 31 zeros", los, 1'b0);
    send_n(1'b0, 31);
    check("R2 before 32nd", los, 1'b0);
    send(1'b0, 1'b0);
    check("R2 at 32nd", los, 1'b1);
    check("R9 los_chg set", los_chg, 1'b1);
    send(1'b1, 1'b0);
    check("R9 los_chg drop", los_chg, 1'b0);
    send_n(1'b1, 30);
    check("R3 before window end", los, 1'b1);
    send(1'b1, 1'b0);
    check("R3 window end", los, 1'b0);
    check("R9 los_chg clear", los_chg, 1'b1);
  endtask

  task automatic t_los_restart;
    send_n(1'b0, 32);
    check("R2 redeclare", los, 1'b1);
    send_n(1'b1, 10); send_n(1'b0, 3); send_n(1'b1, 18);
    check("R4 run of 3 keeps window", los, 1'b1);
    send(1'b1, 1'b0);
    check("R4 run of 3 no restart", los, 1'b0);
    send_n(1'b0, 32);
    send_n(1'b1, 20); send_n(1'b0, 4); send_n(1'b1, 31);
    check("R4 run of 4 restarts", los, 1'b1);
    send(1'b1, 1'b0);
    check("R4 restarted window end", los, 1'b0);
  endtask

  task automatic t_idle;
    send_n(1'b0, 31);
    @(negedge clk); bit_en = 1'b0; bit_d = 1'b0; fs = 1'b1;
    repeat (40) @(negedge clk);
    check("R10 idle no declare", los, 1'b0);
    send(1'b0, 1'b0);
    check("R10 run continues", los, 1'b1);
    send_n(1'b1, 32);
    check("R3 cleared after idle", los, 1'b0);
  endtask

  task automatic t_ais_declare;
    fmt = 1'b1;
    frame(LSHORT, 0, 1'b1);
    check("R6 one sparse frame", ais, 1'b0);
    frame_head(LSHORT, 7, 1'b1);
    check("R6 before last bit", ais, 1'b0);
    send(1'b1, 1'b0);
    check("R6 second sparse frame", ais, 1'b1);
    check("R9 ais_chg set", ais_chg, 1'b1);
    send(1'b1, 1'b1);
    check("R9 ais_chg drop", ais_chg, 1'b0);
  endtask

  task automatic t_ais_clear;
    frame(LSHORT, 8, 1'b1);
    frame(LSHORT, 7, 1'b1);
    frame(LSHORT, 8, 1'b1);
    check("R8 sparse frame resets clear count", ais, 1'b1);
    frame(LSHORT, 8, 1'b1);
    check("R7 two dense frames", ais, 1'b0);
    check("R9 ais_chg clear", ais_chg, 1'b1);
    frame(LSHORT, 0, 1'b1);
    frame(LSHORT, 9, 1'b1);
    frame(LSHORT, 3, 1'b1);
    check("R8 dense frame resets declare count", ais, 1'b0);
    frame(LSHORT, 3, 1'b1);
    check("R6 after reset count", ais, 1'b1);
    frame(LSHORT, 8, 1'b1);
    frame(LSHORT, 8, 1'b1);
    check("R7 cleared again", ais, 1'b0);
  endtask

  task automatic t_long_format;
    fmt = 1'b0;
    frame(LLONG, 8, 1'b1);
    frame(LLONG, 8, 1'b1);
    check("R5 long frames dense", ais, 1'b0);
    frame(LLONG, 0, 1'b0);
    frame_head(LLONG, 0, 1'b0);
    check("R5 free-run before last", ais, 0);
    send(1'b1, 1'b0);
    check("R5 free-run frame end", ais, 1'b1);
  endtask

  task automatic t_early_strobe;
    fmt = 1'b1;
    for (int i = 0; i < 100; i++) send(1'b1, i == 0);
    frame(LSHORT, 8, 1'b1);
    check("R5 partial discarded", ais, 1'b1);
    frame(LSHORT, 8, 1'b1);
    check("R5 early strobe realigns", ais, 1'b0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2;
    t_reset();
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk); #2;
    t_reset();
    t_los_declare();
    t_los_restart();
    t_idle();
    t_ais_declare();
    t_ais_clear();
    t_long_format();
    t_early_strobe();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      vectors++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule